// File: doc/BRIEF.md
# Vertical-blank interrupt and status flag registers

This block turns the raster position of a video timing generator into the interrupt and status information that a processor polls. It watches the vertical count for the start of vertical blanking. It latches a vertical-blank NMI flag, and it raises a one-cycle NMI request when NMI delivery is enabled. It also keeps an IRQ flag that an external comparator sets with a pulse.

Software sees the state through three read ports, selected by a two-bit address. Reading the NMI or the IRQ port clears that flag at the end of the read cycle. The third port reports live blanking state and a joypad-busy window, and it has no side effect. Bits with no meaning are filled from the open-bus byte, so the block returns what the data bus last held. The read data is combinational. It shows the flag value from before the clear, in the same cycle as the strobe.

Top module: `vstat_regs`

## Requirements
- R1: The raster is in vertical blank when `vcount` is 225 or more in standard mode, or 240 or more when `overscan` is high. Lines 225 to 239 are not blank in overscan mode.
- R2: On the clock edge that first sees the raster in vertical blank, the NMI flag is set.
- R3: `nmi_req` is high for exactly one cycle, after the edge that sets the NMI flag, and only if `nmi_enable` was high during that entry cycle.
- R4: On the clock edge that first sees the raster outside vertical blank, the NMI flag is cleared.
- R5: A strobed read with `rd_addr`=0 returns {NMI flag, open_bus[6:4], 4'h2} and clears the NMI flag at that edge. Cycles without `rd_strobe` leave the flag alone.
- R6: A strobed read with `rd_addr`=1 returns {IRQ flag, open_bus[6:0]} and clears the IRQ flag at that edge.
- R7: An `irq_set` pulse sets `irq_line` on the next edge, and the line stays high until an IRQ-port read clears it.
- R8: When a set event (vertical-blank entry or `irq_set`) and a read-clear of the same flag fall in one cycle, the flag ends up set. The read still returns the old value.
- R9: A strobed read with `rd_addr`=2 returns bit 7 high while the raster is in vertical blank (R1 thresholds). A read with `rd_addr`=3, or any cycle without a strobe, returns `open_bus`.
- R10: In the `rd_addr`=2 byte, bit 6 is high when `hcount` is 2 or less, or 1096 or more.
- R11: In the `rd_addr`=2 byte, bit 0 is high when `vcount` is from the blank start line through blank start + 2. Bits 5:1 are open_bus[5:1].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hcount | input | 11 | Horizontal raster count |
| vcount | input | 9 | Vertical raster count |
| overscan | input | 1 | High selects the taller picture (blank starts at 240) |
| nmi_enable | input | 1 | Allows the NMI request pulse |
| irq_set | input | 1 | One-cycle pulse that sets the IRQ flag |
| rd_strobe | input | 1 | Read access this cycle |
| rd_addr | input | 2 | Port select: 0 NMI, 1 IRQ, 2 blanking status, 3 none |
| open_bus | input | 8 | Last value seen on the data bus |
| rd_data | output | 8 | Read data, valid in the strobe cycle |
| nmi_req | output | 1 | One-cycle NMI request |
| irq_line | output | 1 | IRQ flag, held until read |

## Verification
The bench checks the threshold lines of both modes. Line 225 in overscan mode must not set the flag; a design with the standard threshold hard-wired would set it there. It also checks the horizontal edges at 2/3 and 1095/1096, and the last joypad-busy line against the line after it, where an off-by-one compare shows up as a wrong bit.

The bench lands a read on the cycle of vertical-blank entry, and an IRQ-port read on the same cycle as `irq_set`. A design that lets the clear win loses the interrupt, and the follow-up read finds the flag low.

Vertical blank is also entered with `nmi_enable` low. The flag must still set, but a design that ignores the enable would raise `nmi_req`. The bench repeats reads to confirm that each clear happens once. It also leaves the raster inside blank for several cycles, where a level-triggered design would re-set the flag.

// File: rtl/vstat_pkg.sv
`timescale 1ns/1ps
package vstat_pkg;

  typedef enum logic [1:0] {
    SEL_NMI   = 2'd0,
    SEL_IRQ   = 2'd1,
    SEL_BLANK = 2'd2,
    SEL_NONE  = 2'd3
  } port_sel_e;

  // first line of vertical blank for the selected picture height
  function automatic logic [31:0] blank_line(input logic ovs,
                                             input logic [31:0] std_l,
                                             input logic [31:0] ovs_l);
    return ovs ? ovs_l : std_l;
  endfunction

  function automatic logic in_vblank(input logic [31:0] v, input logic [31:0] start);
    return v >= start;
  endfunction

  function automatic logic in_hblank(input logic [31:0] h,
                                     input logic [31:0] lead_end,
                                     input logic [31:0] trail_start);
    return (h <= lead_end) || (h >= trail_start);
  endfunction

  // window of span lines beginning at the blank start
  function automatic logic in_joy_window(input logic [31:0] v,
                                         input logic [31:0] start,
                                         input logic [31:0] span);
    return (v >= start) && (v < start + span);
  endfunction

endpackage

// File: rtl/vstat_sticky_flag.sv
`timescale 1ns/1ps
module vstat_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_ev,
  input  logic clr_ev,
  output logic flag
);
  // set has priority over clear
  always_ff @(posedge clk) begin
    if (!rst_n)      flag <= 1'b0;
    else if (set_ev) flag <= 1'b1;
    else if (clr_ev) flag <= 1'b0;
  end
endmodule

// File: rtl/vstat_vblank_edge.sv
`timescale 1ns/1ps
module vstat_vblank_edge #(
  parameter int VCW     = 9,
  parameter int VBL_STD = 225,
  parameter int VBL_OVS = 240
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [VCW-1:0] vcount,
  input  logic           overscan,
  input  logic           nmi_enable,
  output logic           rise,
  output logic           fall,
  output logic           nmi_req
);
  import vstat_pkg::*;

  logic valid_now;
  logic valid_q;

  assign valid_now = in_vblank(32'(vcount),
                               blank_line(overscan, 32'(VBL_STD), 32'(VBL_OVS)));
  assign rise = valid_now & ~valid_q;
  assign fall = ~valid_now & valid_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      nmi_req <= 1'b0;
    end else begin
      valid_q <= valid_now;
      nmi_req <= rise & nmi_enable;
    end
  end
endmodule

// File: rtl/vstat_read_mux.sv
`timescale 1ns/1ps
module vstat_read_mux #(
  parameter int         HCW       = 11,
  parameter int         VCW       = 9,
  parameter int         VBL_STD   = 225,
  parameter int         VBL_OVS   = 240,
  parameter int         HBL_LEAD  = 2,
  parameter int         HBL_TRAIL = 1096,
  parameter int         JOY_SPAN  = 3,
  parameter logic [3:0] REV_CODE  = 4'h2
) (
  input  logic           rd_strobe,
  input  logic [1:0]     rd_addr,
  input  logic           nmi_flag,
  input  logic           irq_flag,
  input  logic [HCW-1:0] hcount,
  input  logic [VCW-1:0] vcount,
  input  logic           overscan,
  input  logic [7:0]     open_bus,
  output logic [7:0]     rd_data
);
  import vstat_pkg::*;

  logic [31:0] start_l;
  logic        vb, hb, joy;

  assign start_l = blank_line(overscan, 32'(VBL_STD), 32'(VBL_OVS));
  assign vb  = in_vblank(32'(vcount), start_l);
  assign hb  = in_hblank(32'(hcount), 32'(HBL_LEAD), 32'(HBL_TRAIL));
  assign joy = in_joy_window(32'(vcount), start_l, 32'(JOY_SPAN));

  always_comb begin
    rd_data = open_bus;
    if (rd_strobe) begin
      unique case (port_sel_e'(rd_addr))
        SEL_NMI:   rd_data = {nmi_flag, open_bus[6:4], REV_CODE};
        SEL_IRQ:   rd_data = {irq_flag, open_bus[6:0]};
        SEL_BLANK: rd_data = {vb, hb, open_bus[5:1], joy};
        SEL_NONE:  rd_data = open_bus;
      endcase
    end
  end
endmodule

// File: rtl/vstat_regs.sv
`timescale 1ns/1ps
module vstat_regs #(
  parameter int         HCW       = 11,
  parameter int         VCW       = 9,
  parameter int         VBL_STD   = 225,
  parameter int         VBL_OVS   = 240,
  parameter int         HBL_LEAD  = 2,
  parameter int         HBL_TRAIL = 1096,
  parameter int         JOY_SPAN  = 3,
  parameter logic [3:0] REV_CODE  = 4'h2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [HCW-1:0] hcount,
  input  logic [VCW-1:0] vcount,
  input  logic           overscan,
  input  logic           nmi_enable,
  input  logic           irq_set,
  input  logic           rd_strobe,
  input  logic [1:0]     rd_addr,
  input  logic [7:0]     open_bus,
  output logic [7:0]     rd_data,
  output logic           nmi_req,
  output logic           irq_line
);
  import vstat_pkg::*;

  // named internal events, observed by the bound checker
  logic nmi_rise, nmi_fall, nmi_rd_clr, irq_rd_clr, nmi_flag;

  assign nmi_rd_clr = rd_strobe && (rd_addr == SEL_NMI);
  assign irq_rd_clr = rd_strobe && (rd_addr == SEL_IRQ);

  vstat_vblank_edge #(.VCW(VCW), .VBL_STD(VBL_STD), .VBL_OVS(VBL_OVS)) u_edge (
    .clk(clk), .rst_n(rst_n), .vcount(vcount), .overscan(overscan),
    .nmi_enable(nmi_enable), .rise(nmi_rise), .fall(nmi_fall), .nmi_req(nmi_req)
  );

  vstat_sticky_flag u_nmi_flag (
    .clk(clk), .rst_n(rst_n), .set_ev(nmi_rise),
    .clr_ev(nmi_fall | nmi_rd_clr), .flag(nmi_flag)
  );

  vstat_sticky_flag u_irq_flag (
    .clk(clk), .rst_n(rst_n), .set_ev(irq_set),
    .clr_ev(irq_rd_clr), .flag(irq_line)
  );

  vstat_read_mux #(
    .HCW(HCW), .VCW(VCW), .VBL_STD(VBL_STD), .VBL_OVS(VBL_OVS),
    .HBL_LEAD(HBL_LEAD), .HBL_TRAIL(HBL_TRAIL), .JOY_SPAN(JOY_SPAN), .REV_CODE(REV_CODE)
  ) u_mux (
    .rd_strobe(rd_strobe), .rd_addr(rd_addr), .nmi_flag(nmi_flag), .irq_flag(irq_line),
    .hcount(hcount), .vcount(vcount), .overscan(overscan), .open_bus(open_bus),
    .rd_data(rd_data)
  );
endmodule

// File: rtl/vstat_regs_chk.sv
`timescale 1ns/1ps
module vstat_regs_chk #(
  parameter int         VCW      = 9,
  parameter int         VBL_STD  = 225,
  parameter logic [3:0] REV_CODE = 4'h2
) (
  input logic           clk,
  input logic           rst_n,
  input logic [VCW-1:0] vcount,
  input logic           nmi_rise,
  input logic           nmi_fall,
  input logic           nmi_enable,
  input logic           nmi_rd_clr,
  input logic           nmi_flag,
  input logic           nmi_req,
  input logic           irq_set,
  input logic           irq_rd_clr,
  input logic           irq_line,
  input logic           rd_strobe,
  input logic [1:0]     rd_addr,
  input logic [7:0]     rd_data
);
  AST_RISE_IN_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_rise |-> (32'(vcount) >= 32'(VBL_STD)));                          // R1
  AST_NMI_SET: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_rise |=> nmi_flag);                                               // R2
  AST_NMI_REQ_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_rise && nmi_enable) |=> nmi_req);                                // R3
  AST_NMI_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req |=> !nmi_req);                                                // R3
  AST_NMI_FALL_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_fall |=> !nmi_flag);                                              // R4
  AST_NMI_READ_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_rd_clr && !nmi_rise) |=> !nmi_flag);                             // R5
  AST_REV_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && rd_addr == 2'd0) |-> (rd_data[3:0] == REV_CODE));       // R5
  AST_IRQ_READ_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_rd_clr && !irq_set) |=> !irq_line);                              // R6
  AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set |=> irq_line);                                                // R7
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_line && !irq_rd_clr) |=> irq_line);                              // R7
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_rise && nmi_rd_clr) |=> nmi_flag);                               // R8
endmodule

bind vstat_regs vstat_regs_chk #(.VCW(VCW), .VBL_STD(VBL_STD), .REV_CODE(REV_CODE)) u_chk (
  .clk(clk), .rst_n(rst_n), .vcount(vcount), .nmi_rise(nmi_rise), .nmi_fall(nmi_fall),
  .nmi_enable(nmi_enable), .nmi_rd_clr(nmi_rd_clr), .nmi_flag(nmi_flag), .nmi_req(nmi_req),
  .irq_set(irq_set), .irq_rd_clr(irq_rd_clr), .irq_line(irq_line),
  .rd_strobe(rd_strobe), .rd_addr(rd_addr), .rd_data(rd_data)
);

// File: tb/vstat_regs_tb.sv
`timescale 1ns/1ps
module vstat_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] hcount = '0;
  logic [8:0]  vcount = '0;
  logic        overscan = 1'b0, nmi_enable = 1'b0, irq_set = 1'b0, rd_strobe = 1'b0;
  logic [1:0]  rd_addr = '0;
  logic [7:0]  open_bus = '0;
  logic [7:0]  rd_data;
  logic        nmi_req, irq_line;

  always #4 clk = ~clk;

  vstat_regs u_dut (
    .clk(clk), .rst_n(rst_n), .hcount(hcount), .vcount(vcount), .overscan(overscan),
    .nmi_enable(nmi_enable), .irq_set(irq_set), .rd_strobe(rd_strobe), .rd_addr(rd_addr),
    .open_bus(open_bus), .rd_data(rd_data), .nmi_req(nmi_req), .irq_line(irq_line)
  );

  int n_chk = 0, n_fail = 0;
  logic [7:0] exp_q[$];
  int         tag_q[$];
  event       mon_ev;

  // reference state, updated from the requirements
  bit m_prev = 0, m_nmi = 0, m_irq = 0, m_req = 0;

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // monitor: pops expected read data and compares with the port
  initial forever begin
    @(mon_ev);
    begin
      logic [7:0] e;
      int t;
      string r;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      r = (t == 0) ? "R5 R8 nmi port" : (t == 1) ? "R6 R8 irq port" :
          (t == 2) ? "R9 R10 R11 blank port" : "R9 unused port";
      chk(rd_data === e, r, rd_data, e);
    end
  end

  task automatic step(input int v, input int h, input bit os, input bit en, input bit irqs,
                      input bit rd, input int addr, input logic [7:0] ob);
    int  bs;
    bit  valid, rise, fall;
    logic [7:0] e;
    @(negedge clk);
    vcount = 9'(v); hcount = 11'(h); overscan = os; nmi_enable = en;
    irq_set = irqs; rd_strobe = rd; rd_addr = 2'(addr); open_bus = ob;
    #2;
    bs = os ? 240 : 225;
    if (rd) begin
      case (addr)
        0: e = {m_nmi, ob[6:4], 4'h2};
        1: e = {m_irq, ob[6:0]};
        2: e = {(v >= bs), (h <= 2 || h >= 1096), ob[5:1], (v >= bs && v <= bs + 2)};
        default: e = ob;
      endcase
      exp_q.push_back(e); tag_q.push_back(addr); ->mon_ev;
    end
    valid = (v >= bs);
    rise = valid && !m_prev;
    fall = !valid && m_prev;
    if (rise) m_nmi = 1;
    else if (fall || (rd && addr == 0)) m_nmi = 0;
    m_req = rise && en;
    if (irqs) m_irq = 1;
    else if (rd && addr == 1) m_irq = 0;
    m_prev = valid;
    @(posedge clk); #1;
    chk(nmi_req === m_req, "R3 nmi_req", {7'd0, nmi_req}, {7'd0, m_req});
    chk(irq_line === m_irq, "R7 irq_line", {7'd0, irq_line}, {7'd0, m_irq});
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_fail++;
    $display("FAIL R1 watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // reset state
    step(0, 100, 0, 1, 0, 1, 0, 8'hA5);       // R5: flag clear, rev code
    step(0, 100, 0, 1, 0, 1, 1, 8'h5A);       // R6
    step(0, 100, 0, 1, 0, 1, 3, 8'h3C);       // R9 unused port
    // R1 R2 R3: standard entry with enable
    step(224, 10, 0, 1, 0, 1, 0, 8'hFF);
    step(225, 10, 0, 1, 0, 0, 0, 8'h00);
    step(226, 10, 0, 1, 0, 0, 0, 8'h00);      // R3 pulse gone
    step(226, 10, 0, 1, 0, 0, 0, 8'h00);      // no re-set inside blank
    step(226, 10, 0, 1, 0, 1, 0, 8'h70);      // R5 read 1, clears
    step(226, 10, 0, 1, 0, 1, 0, 8'h70);      // R5 now 0
    // R9 R10 R11 blanking byte
    step(225, 0, 0, 1, 0, 1, 2, 8'h00);
    step(227, 500, 0, 1, 0, 1, 2, 8'h3E);
    step(228, 1096, 0, 1, 0, 1, 2, 8'h00);
    step(228, 1095, 0, 1, 0, 1, 2, 8'hFF);
    // R4: exit and re-entry with enable low
    step(0, 3, 0, 0, 0, 1, 2, 8'h00);
    step(100, 2, 0, 0, 0, 1, 2, 8'h00);
    step(225, 3, 0, 0, 0, 0, 0, 8'h00);       // flag set, no request
    step(230, 3, 0, 0, 0, 1, 0, 8'h00);       // flag still set (no read since)
    step(0, 3, 0, 0, 0, 0, 0, 8'h00);
    step(230, 3, 0, 0, 0, 0, 0, 8'h00);       // re-entry sets
    step(5, 3, 0, 0, 0, 0, 0, 8'h00);         // R4 exit clears
    step(5, 3, 0, 0, 0, 1, 0, 8'h00);         // R4 confirm 0
    // R1 overscan thresholds
    step(225, 3, 1, 1, 0, 1, 2, 8'h00);       // not blank in overscan
    step(239, 3, 1, 1, 0, 1, 0, 8'h00);       // no flag
    step(240, 3, 1, 1, 0, 1, 2, 8'h00);       // R2 entry at 240
    step(242, 3, 1, 1, 0, 1, 2, 8'h00);       // R11 last busy line
    step(243, 3, 1, 1, 0, 1, 2, 8'h00);       // R11 after window
    step(243, 3, 1, 1, 0, 1, 0, 8'h00);
    // R8: entry coincides with NMI read
    step(0, 3, 0, 1, 0, 0, 0, 8'h00);
    step(225, 3, 0, 1, 0, 1, 0, 8'h00);       // returns old 0, set wins
    step(226, 3, 0, 1, 0, 1, 0, 8'h00);       // R8 reads 1
    // R6 R7 R8 IRQ
    step(0, 3, 0, 1, 1, 0, 0, 8'h00);
    step(0, 3, 0, 1, 0, 0, 0, 8'h00);
    step(0, 3, 0, 1, 0, 0, 0, 8'h00);         // R7 held
    step(0, 3, 0, 1, 0, 1, 1, 8'h11);         // R6 reads 1, clears
    step(0, 3, 0, 1, 0, 1, 1, 8'h11);         // R6 now 0
    step(0, 3, 0, 1, 1, 0, 0, 8'h00);
    step(0, 3, 0, 1, 1, 1, 1, 8'h00);         // R8 set wins
    step(0, 3, 0, 1, 0, 1, 1, 8'h00);         // R8 reads 1
    step(0, 3, 0, 1, 0, 0, 0, 8'h00);
    @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule